// File: doc/BRIEF.md
# Manchester Control Command Receiver

This block sits on a front-end board and listens to a single serial control line driven by the back end. The line carries Manchester-coded bits. The receiver samples the line at four times the bit rate on its own sampling clock, recovers each bit from the mid-bit transition, finds frame boundaries with a start pattern, and checks each frame's parity. It then turns each good frame into one action. An action is a register write with an address and data, a readback request for an address, an even or odd test-pulse strobe, or a bunch-crossing counter reset strobe.

The main timing clock of the board arrives on a separate line and is not handled here. Every output is a one-cycle pulse on the sampling clock. The address and data buses are valid only in the cycle where a write or read pulse is high. Broken frames and frames with bad parity raise a one-cycle error pulse and produce no action.

Top module: `mcr_cmd_rx`

## Requirements
- R1: While reset is low, and in the cycle after reset is sampled low, all pulse outputs are low.
- R2: Line coding: a 0 bit is high for the first half of the bit period and low for the second half. A 1 bit is low then high. One bit lasts SPB = 4 sampling cycles. The idle line is low.
- R3: A frame consists of the start bits 1,1,0,1, then a 4-bit opcode, an 8-bit address, a 16-bit data word and one parity bit, each field sent MSB first. The parity bit makes the number of ones over opcode, address, data and parity even.
- R4: Opcode 0x1 gives a one-cycle `reg_wr` pulse, with `reg_addr` and `reg_wdata` equal to the frame's address and data fields in that cycle.
- R5: Opcode 0x2 gives a one-cycle `reg_rd_req` pulse, with `reg_addr` equal to the frame's address field.
- R6: Opcode 0x3 pulses `tp_even`, 0x4 pulses `tp_odd` and 0x5 pulses `bcnt_rst`. Each pulse is one cycle wide and comes in the cycle after the last frame bit is recovered.
- R7: A frame with wrong parity produces no action and a one-cycle `cmd_err` pulse.
- R8: If the mid-bit transition is missing before a frame is complete, the receiver raises a one-cycle `cmd_err` pulse, drops the frame and hunts for the next start pattern.
- R9: Opcodes 0x0 and 0x6 to 0xF are ignored: no action and no error.
- R10: At most one of the six pulse outputs is high in any cycle.
- R11: Bits received outside a frame that do not complete the start pattern are ignored.
- R12: A frame may follow the previous one's last bit with no idle gap and is still decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_line | input | 1 | Serial Manchester control input |
| reg_wr | output | 1 | Register write pulse |
| reg_addr | output | ADDR_W | Register address, valid with `reg_wr` or `reg_rd_req` |
| reg_wdata | output | DATA_W | Write data, valid with `reg_wr` |
| reg_rd_req | output | 1 | Readback request pulse |
| tp_even | output | 1 | Even test-pulse strobe |
| tp_odd | output | 1 | Odd test-pulse strobe |
| bcnt_rst | output | 1 | Bunch-crossing counter reset strobe |
| cmd_err | output | 1 | Code or parity error pulse |

## Verification
The bench sends a frame with a single flipped parity bit. A receiver that computes odd parity, or that skips the parity bit, would either act on that frame or flag the good frames. It cuts a frame off mid-address and leaves the line idle. A receiver that treats every line timeout as the normal end of a frame would stay silent, and one that fails to return to hunting would miss the next frame. It places noise bits right before a start pattern and sends frames back to back with no gap. A start-pattern matcher that is misaligned or reset at the wrong time, or a bit tracker that loses lock at a frame seam, would drop or misread those frames. Unused opcodes must produce nothing at all.

// File: rtl/mcr_pkg.sv
// Package: mcr_pkg
// Shared constants and types for the Manchester control command receiver.
// Assumes a fixed 4-bit opcode field and a 4-bit start pattern.
package mcr_pkg;

    localparam int OP_W      = 4;
    localparam int START_W   = 4;
    localparam logic [START_W-1:0] START_PAT = 4'b1101;

    typedef enum logic [OP_W-1:0] {
        OP_WRITE   = 4'h1,
        OP_READ    = 4'h2,
        OP_TP_EVEN = 4'h3,
        OP_TP_ODD  = 4'h4,
        OP_BC_RST  = 4'h5
    } cmd_op_e;

    typedef enum logic {
        FR_HUNT    = 1'b0,
        FR_COLLECT = 1'b1
    } frame_state_e;

endpackage

// File: rtl/mcr_line_sync.sv
// Module: mcr_line_sync
// Brings the asynchronous serial line into the sampling clock domain
// through a chain of flops. Assumes the line idles low.
module mcr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
        end
    end

    assign line_s = chain[STAGES-1];

endmodule

// File: rtl/mcr_bit_rec.sv
// Module: mcr_bit_rec
// Recovers Manchester bits from the synchronized line. Any transition
// seen while unlocked is taken as a mid-bit edge, which sets the bit
// phase. Once locked, only edges inside a window around the expected
// mid-bit point produce bits; boundary edges are ignored. If no edge
// arrives before the window closes, the tracker pulses `lost` and
// unlocks. Assumes SPB >= 4 samples per bit.
module mcr_bit_rec #(
    parameter int SPB = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic bit_valid,
    output logic bit_val,
    output logic lost
);

    localparam int CW = $clog2(SPB + 3);
    localparam logic [CW-1:0] WIN_LO = CW'(SPB - 1);
    localparam logic [CW-1:0] WIN_HI = CW'(SPB + 1);
    localparam logic [CW-1:0] TMO    = CW'(SPB + 2);

    logic          prev;
    logic          locked;
    logic [CW-1:0] phase;
    logic          edge_seen;

    assign edge_seen = line_s ^ prev;

    // Track the bit phase, emit recovered bits and detect loss of transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev      <= 1'b0;
            locked    <= 1'b0;
            phase     <= '0;
            bit_valid <= 1'b0;
            bit_val   <= 1'b0;
            lost      <= 1'b0;
        end else begin
            prev      <= line_s;
            bit_valid <= 1'b0;
            lost      <= 1'b0;
            if (!locked) begin
                if (edge_seen) begin
                    locked    <= 1'b1;
                    phase     <= CW'(1);
                    bit_valid <= 1'b1;
                    bit_val   <= line_s;
                end
            end else if (edge_seen && phase >= WIN_LO && phase <= WIN_HI) begin
                phase     <= CW'(1);
                bit_valid <= 1'b1;
                bit_val   <= line_s;
            end else if (phase == TMO) begin
                locked <= 1'b0;
                phase  <= '0;
                lost   <= 1'b1;
            end else begin
                phase <= phase + CW'(1);
            end
        end
    end

endmodule

// File: rtl/mcr_framer.sv
// Module: mcr_framer
// Hunts for the start pattern in the recovered bit stream, then gathers
// a fixed-length payload. It pulses `frm_valid` one cycle after the last
// payload bit. Losing bit lock mid-payload pulses `code_err` and returns
// to hunting. Assumes bits arrive MSB first.
module mcr_framer
    import mcr_pkg::*;
#(
    parameter int PAY_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_val,
    input  logic             lost,
    output logic             frm_valid,
    output logic [PAY_W-1:0] frm_payload,
    output logic             code_err
);

    localparam int CNTW = $clog2(PAY_W);
    localparam logic [CNTW-1:0] LAST = CNTW'(PAY_W - 1);

    frame_state_e         state;
    logic [START_W-1:0]   hunt;
    logic [CNTW-1:0]      cnt;
    logic [START_W-1:0]   hunt_next;

    assign hunt_next = {hunt[START_W-2:0], bit_val};

    // Sequence through start-pattern hunting and payload collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= FR_HUNT;
            hunt        <= '0;
            cnt         <= '0;
            frm_payload <= '0;
            frm_valid   <= 1'b0;
            code_err    <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            code_err  <= 1'b0;
            case (state)
                FR_HUNT: begin
                    if (lost) begin
                        hunt <= '0;
                    end else if (bit_valid) begin
                        if (hunt_next == START_PAT) begin
                            state <= FR_COLLECT;
                            cnt   <= '0;
                            hunt  <= '0;
                        end else begin
                            hunt <= hunt_next;
                        end
                    end
                end
                FR_COLLECT: begin
                    if (lost) begin
                        state    <= FR_HUNT;
                        code_err <= 1'b1;
                    end else if (bit_valid) begin
                        frm_payload <= {frm_payload[PAY_W-2:0], bit_val};
                        if (cnt == LAST) begin
                            state     <= FR_HUNT;
                            frm_valid <= 1'b1;
                        end else begin
                            cnt <= cnt + CNTW'(1);
                        end
                    end
                end
                default: state <= FR_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/mcr_cmd_decode.sv
// Module: mcr_cmd_decode
// Splits a completed payload into opcode, address and data fields,
// checks even parity, and raises exactly one action or error pulse.
// Assumes its inputs come straight from registers, so the outputs
// are free of glitches from upstream logic.
module mcr_cmd_decode
    import mcr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int PAY_W  = OP_W + ADDR_W + DATA_W + 1
) (
    input  logic              frm_valid,
    input  logic [PAY_W-1:0]  frm_payload,
    input  logic              code_err,
    output logic              reg_wr,
    output logic              reg_rd_req,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              tp_even,
    output logic              tp_odd,
    output logic              bcnt_rst,
    output logic              cmd_err
);

    logic [OP_W-1:0] op;
    logic            par_bad;
    logic            good;

    // Extract fields and qualify the frame by its parity.
    always_comb begin
        op        = frm_payload[PAY_W-1 -: OP_W];
        reg_addr  = frm_payload[PAY_W-1-OP_W -: ADDR_W];
        reg_wdata = frm_payload[DATA_W:1];
        par_bad   = ^frm_payload;
        good      = frm_valid && !par_bad;
    end

    // Map the opcode of a good frame to its single action pulse.
    always_comb begin
        reg_wr     = good && (op == OP_WRITE);
        reg_rd_req = good && (op == OP_READ);
        tp_even    = good && (op == OP_TP_EVEN);
        tp_odd     = good && (op == OP_TP_ODD);
        bcnt_rst   = good && (op == OP_BC_RST);
        cmd_err    = code_err || (frm_valid && par_bad);
    end

endmodule

// File: rtl/mcr_cmd_rx.sv
// Module: mcr_cmd_rx
// Top of the Manchester control command receiver: synchronizer, bit
// recovery, framing and command decode. Assumes clk runs at SPB times
// the control bit rate and that the line idles low.
module mcr_cmd_rx
    import mcr_pkg::*;
#(
    parameter int SPB         = 4,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_line,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd_req,
    output logic              tp_even,
    output logic              tp_odd,
    output logic              bcnt_rst,
    output logic              cmd_err
);

    localparam int PAY_W = OP_W + ADDR_W + DATA_W + 1;

    logic             line_s;
    logic             s_bit_valid;
    logic             s_bit_val;
    logic             s_lost;
    logic             s_frm_valid;
    logic [PAY_W-1:0] s_payload;
    logic             s_code_err;

    mcr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (ctl_line),
        .line_s  (line_s)
    );

    mcr_bit_rec #(.SPB(SPB)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .bit_valid (s_bit_valid),
        .bit_val   (s_bit_val),
        .lost      (s_lost)
    );

    mcr_framer #(.PAY_W(PAY_W)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid   (s_bit_valid),
        .bit_val     (s_bit_val),
        .lost        (s_lost),
        .frm_valid   (s_frm_valid),
        .frm_payload (s_payload),
        .code_err    (s_code_err)
    );

    mcr_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAY_W(PAY_W)) u_dec (
        .frm_valid   (s_frm_valid),
        .frm_payload (s_payload),
        .code_err    (s_code_err),
        .reg_wr      (reg_wr),
        .reg_rd_req  (reg_rd_req),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .tp_even     (tp_even),
        .tp_odd      (tp_odd),
        .bcnt_rst    (bcnt_rst),
        .cmd_err     (cmd_err)
    );

endmodule

// File: rtl/mcr_cmd_rx_chk.sv
// Module: mcr_cmd_rx_chk
// Property checker for mcr_cmd_rx. It watches the pulse outputs against
// the recovered-bit and lost-lock events of the bit tracker.
module mcr_cmd_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic lost,
    input logic reg_wr,
    input logic reg_rd_req,
    input logic tp_even,
    input logic tp_odd,
    input logic bcnt_rst,
    input logic cmd_err
);

    logic any_act;
    assign any_act = reg_wr | reg_rd_req | tp_even | tp_odd | bcnt_rst;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !(any_act | cmd_err));

    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd_req, tp_even, tp_odd, bcnt_rst, cmd_err}));

    p_act_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_act |-> $past(bit_valid));

    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |=> !reg_rd_req);

    p_tpe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tp_even |=> !tp_even);

    p_tpo_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tp_odd |=> !tp_odd);

    p_bcr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_rst |=> !bcnt_rst);

    // R7 and R8: an error pulse follows either a completed frame bit or lost lock.
    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(bit_valid || lost));

endmodule

bind mcr_cmd_rx mcr_cmd_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (s_bit_valid),
    .lost       (s_lost),
    .reg_wr     (reg_wr),
    .reg_rd_req (reg_rd_req),
    .tp_even    (tp_even),
    .tp_odd     (tp_odd),
    .bcnt_rst   (bcnt_rst),
    .cmd_err    (cmd_err)
);

// File: tb/test_mcr_cmd_rx.sv
// Scoreboard bench for mcr_cmd_rx. Driver tasks encode frames on the line
// and queue the expected action. A monitor compares each output pulse
// against the head of the queue.
module test_mcr_cmd_rx;

    localparam int K_WR  = 0;
    localparam int K_RD  = 1;
    localparam int K_TPE = 2;
    localparam int K_TPO = 3;
    localparam int K_BCR = 4;
    localparam int K_ERR = 5;

    typedef struct {
        int          kind;
        logic [7:0]  addr;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_line = 1'b0;
    logic        reg_wr, reg_rd_req, tp_even, tp_odd, bcnt_rst, cmd_err;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;

    int   checks = 0;
    int   fails  = 0;
    exp_t exq[$];

    always #2 clk = ~clk;

    mcr_cmd_rx i_mcr_cmd_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_line   (ctl_line),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rd_req (reg_rd_req),
        .tp_even    (tp_even),
        .tp_odd     (tp_odd),
        .bcnt_rst   (bcnt_rst),
        .cmd_err    (cmd_err)
    );

    // One Manchester bit (R2): 0 = high then low, 1 = low then high.
    task automatic send_bit(input logic b);
        repeat (2) begin @(negedge clk); ctl_line = b ? 1'b0 : 1'b1; end
        repeat (2) begin @(negedge clk); ctl_line = b ? 1'b1 : 1'b0; end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); ctl_line = 1'b0; end
    endtask

    // Encode a full frame (R3), optionally with a flipped parity bit.
    task automatic send_frame(input logic [3:0] op, input logic [7:0] a,
                              input logic [15:0] d, input logic bad_par,
                              input string tag);
        logic [32:0] bits;
        logic        par;
        exp_t        e;
        par  = (^{op, a, d}) ^ bad_par;
        bits = {4'b1101, op, a, d, par};
        e.addr = a; e.data = d; e.tag = tag; e.kind = -1;
        if (bad_par) e.kind = K_ERR;
        else if (op == 4'h1) e.kind = K_WR;
        else if (op == 4'h2) e.kind = K_RD;
        else if (op == 4'h3) e.kind = K_TPE;
        else if (op == 4'h4) e.kind = K_TPO;
        else if (op == 4'h5) e.kind = K_BCR;
        if (e.kind >= 0) exq.push_back(e);
        for (int i = 32; i >= 0; i--) send_bit(bits[i]);
    endtask

    task automatic expect_drained(input string tag);
        idle(16);
        checks++;
        if (exq.size() != 0) begin
            fails++;
            $display("FAIL %s: pending expected actions actual=%0d expected=0", tag, exq.size());
            exq.delete();
        end
    endtask

    // Monitor: compare every output pulse with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            int   n;
            int   k;
            exp_t e;
            n = int'(reg_wr) + int'(reg_rd_req) + int'(tp_even) + int'(tp_odd)
              + int'(bcnt_rst) + int'(cmd_err);
            if (n > 1) begin
                checks++; fails++;
                $display("FAIL R10: pulses in one cycle actual=%0d expected=1", n);
            end else if (n == 1) begin
                k = reg_wr ? K_WR : reg_rd_req ? K_RD : tp_even ? K_TPE :
                    tp_odd ? K_TPO : bcnt_rst ? K_BCR : K_ERR;
                checks++;
                if (exq.size() == 0) begin
                    fails++;
                    $display("FAIL R9: unexpected pulse kind actual=%0d expected=none", k);
                end else begin
                    e = exq.pop_front();
                    if (k != e.kind) begin
                        fails++;
                        $display("FAIL %s: kind actual=%0d expected=%0d", e.tag, k, e.kind);
                    end else if ((k == K_WR || k == K_RD) && reg_addr != e.addr) begin
                        fails++;
                        $display("FAIL %s: addr actual=%h expected=%h", e.tag, reg_addr, e.addr);
                    end else if (k == K_WR && reg_wdata != e.data) begin
                        fails++;
                        $display("FAIL %s: data actual=%h expected=%h", e.tag, reg_wdata, e.data);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        exp_t e;
        // R1: outputs quiet while in reset.
        repeat (3) @(negedge clk);
        checks++;
        if ({reg_wr, reg_rd_req, tp_even, tp_odd, bcnt_rst, cmd_err} != 6'b0) begin
            fails++;
            $display("FAIL R1: pulses in reset actual=%b expected=000000",
                     {reg_wr, reg_rd_req, tp_even, tp_odd, bcnt_rst, cmd_err});
        end
        @(negedge clk); rst_n = 1'b1;
        idle(8);

        send_frame(4'h1, 8'h3C, 16'hA55A, 1'b0, "R4"); expect_drained("R4");
        send_frame(4'h1, 8'hFF, 16'h0001, 1'b0, "R4"); expect_drained("R4");
        send_frame(4'h2, 8'h81, 16'h0000, 1'b0, "R5"); expect_drained("R5");
        send_frame(4'h3, 8'h00, 16'h0000, 1'b0, "R6"); expect_drained("R6");
        send_frame(4'h4, 8'h12, 16'hFFFF, 1'b0, "R6"); expect_drained("R6");
        send_frame(4'h5, 8'h00, 16'h1234, 1'b0, "R6"); expect_drained("R6");

        // R7: flipped parity on a write gives an error, no write.
        send_frame(4'h1, 8'h77, 16'hBEEF, 1'b1, "R7"); expect_drained("R7");

        // R9: unused opcodes do nothing.
        send_frame(4'h0, 8'h10, 16'h2222, 1'b0, "R9");
        send_frame(4'h7, 8'h20, 16'h3333, 1'b0, "R9");
        send_frame(4'hF, 8'hAA, 16'h5555, 1'b0, "R9");
        expect_drained("R9");

        // R8: frame cut off mid-address, then a good frame must still decode.
        e.kind = K_ERR; e.addr = 8'h00; e.data = 16'h0000; e.tag = "R8";
        exq.push_back(e);
        begin
            logic [10:0] part;
            part = {4'b1101, 4'h1, 3'b101};
            for (int i = 10; i >= 0; i--) send_bit(part[i]);
        end
        idle(20);
        send_frame(4'h2, 8'h5A, 16'h0000, 1'b0, "R8"); expect_drained("R8");

        // R11: noise bits directly before a start pattern are ignored.
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        send_frame(4'h1, 8'h0F, 16'hC3C3, 1'b0, "R11"); expect_drained("R11");

        // R12: back-to-back frames with no idle gap.
        send_frame(4'h3, 8'h00, 16'h0000, 1'b0, "R12");
        send_frame(4'h1, 8'hE1, 16'h8001, 1'b0, "R12");
        send_frame(4'h5, 8'h01, 16'h0000, 1'b0, "R12");
        expect_drained("R12");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule